// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sequences entry into an exception handler for a small 32-bit RISC core whose branches have a delay slot. It holds the status register and three save registers: the saved program counter, the saved faulting address and the saved status. A requester offers an exception together with the handler's vector address and the faulting effective address, using a valid/ready handshake.

If a delay-slot instruction is pending, the block first asks the retire stage to finish that instruction. It then commits every save and every status-bit change in one clock cycle and emits a one-cycle redirect. The redirect carries the vector, which the fetch stage loads into both its current and its next program counter. If exceptions are disabled when a request is accepted, the block saves nothing, raises a sticky halt and takes no further requests until reset. Software reaches the status and save registers through a write port that always yields to exception entry.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status register reads 0x0003 (supervisor bit 0 and exception-enable bit 1 set, instruction-translation bit 2 and data-translation bit 3 clear). The saved PC, saved address and saved status read zero. `halt`, `redirect_valid` and `ds_run` are low and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays low until the entry completes.
- R3: A request whose `pc_next` differs from `pc_cur + 4` (modulo 2^32) drives `ds_run` high from the next cycle. `ds_run` stays high, with no redirect, until a cycle in which `ds_done` is high. When `pc_next` equals `pc_cur + 4`, `ds_run` stays low.
- R4: If status bit 1 is clear when a request is accepted, `halt` rises on the next cycle and stays high, and `req_ready` stays low. No save register changes.
- R5: The saved PC becomes `pc_cur` with bits 1:0 forced to zero. `pc_cur` is sampled in the commit cycle, which is the cycle right before `redirect_valid`.
- R6: The saved address becomes the `req_ea` value presented with the accepted request.
- R7: The saved status becomes the full status register as it was just before the entry changed it.
- R8: On entry, status bits 2 and 3 are cleared, bit 0 is set and bit 1 is cleared. All other status bits keep their value.
- R9: `redirect_valid` is a one-cycle pulse, and `redirect_pc` equals the request's vector. It is visible in the same cycle as the committed save and status values.
- R10: A software write (`spr_we`) with `spr_sel` 0 = status (low 16 bits of data), 1 = saved PC, 2 = saved address, 3 = saved status updates that register on the next edge. A software write in the commit cycle is discarded in favour of the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_vector | input | AW | Handler vector address |
| req_ea | input | AW | Faulting effective address |
| pc_cur | input | AW | Current program counter from fetch |
| pc_next | input | AW | Next program counter from fetch |
| ds_run | output | 1 | Ask the retire stage to complete the pending delay-slot instruction |
| ds_done | input | 1 | Delay-slot instruction has retired |
| redirect_valid | output | 1 | One-cycle redirect of current and next PC |
| redirect_pc | output | AW | Vector to load into both program counters |
| halt | output | 1 | Fatal halt: exception taken while disabled |
| spr_we | input | 1 | Software register write strobe |
| spr_sel | input | 2 | Write target: 0 status, 1 saved PC, 2 saved address, 3 saved status |
| spr_wdata | input | AW | Write data |
| sr | output | SRW | Status register |
| epcr | output | AW | Saved program counter |
| eear | output | AW | Saved effective address |
| esr | output | SRW | Saved status |

## Verification
The bench builds the block with its defaults, AW = 32 and SRW = 16. The 32-bit address width makes the wrap case reachable: a PC of 0xFFFFFFFC followed by 0x00000000 must count as sequential. The sixteen status bits leave twelve bits that no entry touches, so patterns in bits 15:4 show that entry preserves the unrelated status bits and that the saved status copies all of them. Delay-slot waits of zero and several cycles, unaligned PCs and a program counter that moves while the slot retires fix the cycle in which the PC is sampled.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int unsigned SR_SUPV = 0;
    localparam int unsigned SR_EXEN = 1;
    localparam int unsigned SR_IMMU = 2;
    localparam int unsigned SR_DMMU = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DSWAIT = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HALT   = 2'd3
    } ent_state_e;

    typedef enum logic [1:0] {
        SEL_SR  = 2'd0,
        SEL_EPC = 2'd1,
        SEL_EEA = 2'd2,
        SEL_ESR = 2'd3
    } spr_sel_e;
endpackage

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vector,
    input  logic [AW-1:0] req_ea,
    input  logic [AW-1:0] pc_cur,
    input  logic [AW-1:0] pc_next,
    input  logic          exc_en,
    input  logic          ds_done,
    output logic          ds_run,
    output logic          commit,
    output logic [AW-1:0] commit_ea,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc,
    output logic          halt
);
    localparam logic [AW-1:0] INSN_STEP = AW'(4);

    typedef struct packed {
        ent_state_e    st;
        logic [AW-1:0] vec;
        logic [AW-1:0] ea;
        logic          redir;
    } seq_t;

    seq_t seq_d, seq_q;
    logic slot_pending;

    assign slot_pending = (pc_next != (pc_cur + INSN_STEP));

    always_comb begin
        seq_d       = seq_q;
        seq_d.redir = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.vec = req_vector;
                    seq_d.ea  = req_ea;
                    if (!exc_en)           seq_d.st = ST_HALT;
                    else if (slot_pending) seq_d.st = ST_DSWAIT;
                    else                   seq_d.st = ST_COMMIT;
                end
            end
            ST_DSWAIT: begin
                if (ds_done) seq_d.st = ST_COMMIT;
            end
            ST_COMMIT: begin
                seq_d.redir = 1'b1;
                seq_d.st    = ST_IDLE;
            end
            default: seq_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, vec: '0, ea: '0, redir: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready      = (seq_q.st == ST_IDLE);
    assign ds_run         = (seq_q.st == ST_DSWAIT);
    assign commit         = (seq_q.st == ST_COMMIT);
    assign halt           = (seq_q.st == ST_HALT);
    assign commit_ea      = seq_q.ea;
    assign redirect_valid = seq_q.redir;
    assign redirect_pc    = seq_q.vec;
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
    import exc_entry_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned SRW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           commit,
    input  logic [AW-1:0]  commit_pc,
    input  logic [AW-1:0]  commit_ea,
    input  logic           spr_we,
    input  logic [1:0]     spr_sel,
    input  logic [AW-1:0]  spr_wdata,
    output logic [SRW-1:0] sr,
    output logic [AW-1:0]  epcr,
    output logic [AW-1:0]  eear,
    output logic [SRW-1:0] esr
);
    localparam logic [SRW-1:0] SR_RST   = SRW'((1 << SR_SUPV) | (1 << SR_EXEN));
    localparam logic [AW-1:0]  PC_ALIGN = ~AW'(3);

    typedef struct packed {
        logic [SRW-1:0] sr;
        logic [AW-1:0]  epc;
        logic [AW-1:0]  eea;
        logic [SRW-1:0] esr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (commit) begin
            regs_d.esr          = regs_q.sr;
            regs_d.epc          = commit_pc & PC_ALIGN;
            regs_d.eea          = commit_ea;
            regs_d.sr[SR_DMMU]  = 1'b0;
            regs_d.sr[SR_IMMU]  = 1'b0;
            regs_d.sr[SR_SUPV]  = 1'b1;
            regs_d.sr[SR_EXEN]  = 1'b0;
        end else if (spr_we) begin
            unique case (spr_sel)
                SEL_SR:  regs_d.sr  = spr_wdata[SRW-1:0];
                SEL_EPC: regs_d.epc = spr_wdata;
                SEL_EEA: regs_d.eea = spr_wdata;
                default: regs_d.esr = spr_wdata[SRW-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{sr: SR_RST, epc: '0, eea: '0, esr: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sr   = regs_q.sr;
    assign epcr = regs_q.epc;
    assign eear = regs_q.eea;
    assign esr  = regs_q.esr;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned SRW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_vector,
    input  logic [AW-1:0]  req_ea,
    input  logic [AW-1:0]  pc_cur,
    input  logic [AW-1:0]  pc_next,
    output logic           ds_run,
    input  logic           ds_done,
    output logic           redirect_valid,
    output logic [AW-1:0]  redirect_pc,
    output logic           halt,
    input  logic           spr_we,
    input  logic [1:0]     spr_sel,
    input  logic [AW-1:0]  spr_wdata,
    output logic [SRW-1:0] sr,
    output logic [AW-1:0]  epcr,
    output logic [AW-1:0]  eear,
    output logic [SRW-1:0] esr
);
    logic          commit;
    logic [AW-1:0] commit_ea;

    exc_entry_seq #(.AW(AW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vector     (req_vector),
        .req_ea         (req_ea),
        .pc_cur         (pc_cur),
        .pc_next        (pc_next),
        .exc_en         (sr[SR_EXEN]),
        .ds_done        (ds_done),
        .ds_run         (ds_run),
        .commit         (commit),
        .commit_ea      (commit_ea),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .halt           (halt)
    );

    exc_entry_regs #(.AW(AW), .SRW(SRW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .commit_pc (pc_cur),
        .commit_ea (commit_ea),
        .spr_we    (spr_we),
        .spr_sel   (spr_sel),
        .spr_wdata (spr_wdata),
        .sr        (sr),
        .epcr      (epcr),
        .eear      (eear),
        .esr       (esr)
    );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned SRW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [AW-1:0]  req_vector,
    input logic [AW-1:0]  req_ea,
    input logic [AW-1:0]  pc_cur,
    input logic [AW-1:0]  pc_next,
    input logic           ds_run,
    input logic           ds_done,
    input logic           redirect_valid,
    input logic [AW-1:0]  redirect_pc,
    input logic           halt,
    input logic           spr_we,
    input logic [1:0]     spr_sel,
    input logic [AW-1:0]  spr_wdata,
    input logic [SRW-1:0] sr,
    input logic [AW-1:0]  epcr,
    input logic [AW-1:0]  eear,
    input logic [SRW-1:0] esr
);
    localparam logic [AW-1:0] STEP = AW'(4);
    localparam logic [AW-1:0] MASK = ~AW'(3);

    logic accept;
    assign accept = req_valid && req_ready;

    p_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    p_ds_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ds_run && !ds_done |=> ds_run && !redirect_valid);

    p_no_ds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && sr[SR_EXEN] && (pc_next == pc_cur + STEP) |=> !ds_run);

    p_halt_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !sr[SR_EXEN] |=> halt);

    p_halt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt && !req_ready && !redirect_valid);

    p_epc_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> epcr == ($past(pc_cur) & MASK));

    p_esr_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> esr == $past(sr));

    p_sr_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> sr[SR_SUPV] && !sr[SR_EXEN] && !sr[SR_IMMU] && !sr[SR_DMMU]);

    p_redir_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    p_spr_epc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spr_we && (spr_sel == SEL_EPC) |=> redirect_valid || (epcr == $past(spr_wdata)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .SRW(SRW)) u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
    localparam int unsigned AW  = 32;
    localparam int unsigned SRW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [AW-1:0]  req_vector = '0;
    logic [AW-1:0]  req_ea = '0;
    logic [AW-1:0]  pc_cur = '0;
    logic [AW-1:0]  pc_next = 32'd4;
    logic           ds_run;
    logic           ds_done = 1'b0;
    logic           redirect_valid;
    logic [AW-1:0]  redirect_pc;
    logic           halt;
    logic           spr_we = 1'b0;
    logic [1:0]     spr_sel = '0;
    logic [AW-1:0]  spr_wdata = '0;
    logic [SRW-1:0] sr;
    logic [AW-1:0]  epcr;
    logic [AW-1:0]  eear;
    logic [SRW-1:0] esr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.AW(AW), .SRW(SRW)) dut (.*);

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] nxt;
        logic [31:0] ret;
        logic [31:0] vec;
        logic [31:0] ea;
        logic [15:0] sr0;
        logic [7:0]  lat;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_1000, 32'h0000_1004, 32'h0000_1000, 32'h0000_0100, 32'hDEAD_BEEF, 16'h0003, 8'd0},
        '{32'h0000_2003, 32'h0000_2007, 32'h0000_2003, 32'h0000_0200, 32'h1234_5678, 16'h000F, 8'd0},
        '{32'h0000_3000, 32'h0000_4000, 32'h0000_4002, 32'h0000_0300, 32'h0000_0000, 16'hF00B, 8'd2},
        '{32'h0000_5000, 32'h0000_5008, 32'h0000_5008, 32'h0000_0400, 32'hFFFF_FFFC, 16'h00F7, 8'd0},
        '{32'hFFFF_FFFC, 32'h0000_0000, 32'hFFFF_FFFC, 32'h0000_0800, 32'hA5A5_A5A5, 16'h0006, 8'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic spr_wr(input logic [1:0] sel, input logic [31:0] data);
        spr_we    = 1'b1;
        spr_sel   = sel;
        spr_wdata = data;
        @(negedge clk);
        spr_we    = 1'b0;
    endtask

    function automatic logic [15:0] entered_sr(input logic [15:0] s);
        return (s & 16'hFFF0) | 16'h0001;
    endfunction

    initial begin
        logic [15:0] prev_sr;
        logic [31:0] keep_epc;
        logic [15:0] keep_esr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 sr", 32'(sr), 32'h0003);
        chk("R1 epcr", epcr, 32'h0);
        chk("R1 eear", eear, 32'h0);
        chk("R1 esr", 32'(esr), 32'h0);
        chk("R1 halt", 32'(halt), 32'h0);
        chk("R1 ready", 32'(req_ready), 32'h1);
        chk("R1 redirect", 32'(redirect_valid), 32'h0);
        chk("R1 ds_run", 32'(ds_run), 32'h0);

        for (int i = 0; i < NV; i++) begin
            bit slot;
            slot = (TBL[i].nxt != TBL[i].pc + 32'd4);
            spr_wr(2'd0, 32'(TBL[i].sr0));
            chk("R10 sr write", 32'(sr), 32'(TBL[i].sr0));
            prev_sr    = sr;
            pc_cur     = TBL[i].pc;
            pc_next    = TBL[i].nxt;
            req_vector = TBL[i].vec;
            req_ea     = TBL[i].ea;
            req_valid  = 1'b1;
            @(negedge clk);
            req_valid  = 1'b0;
            req_ea     = 32'h0BAD_0BAD;
            chk("R2 ready low", 32'(req_ready), 32'h0);
            chk("R3 ds_run", 32'(ds_run), 32'(slot));
            if (slot) begin
                for (int k = 0; k < int'(TBL[i].lat); k++) begin
                    @(negedge clk);
                    chk("R3 wait", 32'({ds_run, redirect_valid}), 32'h2);
                end
                ds_done = 1'b1;
                pc_cur  = TBL[i].ret;
                @(negedge clk);
                ds_done = 1'b0;
            end
            chk("R9 no early redirect", 32'(redirect_valid), 32'h0);
            @(negedge clk);
            chk("R9 redirect", 32'(redirect_valid), 32'h1);
            chk("R9 vector", redirect_pc, TBL[i].vec);
            chk("R5 epcr", epcr, TBL[i].ret & 32'hFFFF_FFFC);
            chk("R6 eear", eear, TBL[i].ea);
            chk("R7 esr", 32'(esr), 32'(prev_sr));
            chk("R8 sr", 32'(sr), 32'(entered_sr(prev_sr)));
            @(negedge clk);
            chk("R9 pulse", 32'(redirect_valid), 32'h0);
        end

        // R10: save registers through the write port
        spr_wr(2'd1, 32'hCAFE_0001);
        chk("R10 epcr write", epcr, 32'hCAFE_0001);
        spr_wr(2'd2, 32'h7777_1111);
        chk("R10 eear write", eear, 32'h7777_1111);
        spr_wr(2'd3, 32'h0000_5A5A);
        chk("R10 esr write", 32'(esr), 32'h5A5A);

        // R10: entry wins over a software write in the commit cycle
        spr_wr(2'd0, 32'h0000_0003);
        pc_cur = 32'h0000_6000; pc_next = 32'h0000_6004;
        req_vector = 32'h0000_0500; req_ea = 32'h0000_0044;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        spr_wr(2'd0, 32'h0000_AAAA);
        chk("R10 priority sr", 32'(sr), 32'h0001);
        chk("R10 priority redirect", 32'(redirect_valid), 32'h1);
        @(negedge clk);

        // R4: exception while disabled halts and saves nothing
        spr_wr(2'd0, 32'h0000_0001);
        spr_wr(2'd1, 32'h1234_5678);
        keep_epc = epcr;
        keep_esr = esr;
        pc_cur = 32'h0000_7000; pc_next = 32'h0000_9000;
        req_vector = 32'h0000_0600; req_ea = 32'h0000_0888;
        req_valid = 1'b1;
        @(negedge clk);
        chk("R4 halt", 32'(halt), 32'h1);
        chk("R4 ready", 32'(req_ready), 32'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 sticky", 32'({halt, req_ready, redirect_valid, ds_run}), 32'h8);
        end
        req_valid = 1'b0;
        chk("R4 epcr kept", epcr, keep_epc);
        chk("R4 esr kept", 32'(esr), 32'(keep_esr));
        chk("R4 sr kept", 32'(sr), 32'h0001);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule